// File: doc/BRIEF.md
# I2C Channel Select Register

This block is an I2C target that owns a single 8-bit control byte used to steer a two-way downstream bus switch. It samples the bus clock and data lines with a fast system clock, cleans them through synchronizer flops and a small majority vote, and recognises START and STOP conditions from the cleaned lines. It answers to a 7-bit address whose top four bits are fixed and whose bottom three come from strap pins. Up to eight of these blocks can therefore share one bus.

A master writes the control byte to choose a downstream channel. The choice is not applied at once. It is held as pending and reaches the registered one-hot enable outputs only when a STOP closes the transfer. A repeated START throws the pending choice away. On a read, the block returns the active selection together with the live interrupt request level of each channel. The register value is also brought out on a debug port.

Top module: `chansel_i2c_top`

## Requirements
- R1: The block acknowledges only the address {1110, strap_addr[2:0]} (bit 0 of the address byte is the read/not-write flag). After any other address it does not drive SDA and ignores the bus until the next START.
- R2: After a matching address byte, and after each written data byte, the block pulls SDA low for the ninth clock pulse and releases it after that pulse.
- R3: A written byte does not change chan_en or the selection field of ctrl_q until the next STOP. If several bytes are written in one transfer, the last one is applied.
- R4: After reset the selection is 000, chan_en is 00, ctrl_q is 0x00 while irq_req is 00, and sda_pull is 0.
- R5: Bits 2..0 of the control byte give the selection: 100 sets chan_en=01 (channel 0), 101 sets chan_en=10 (channel 1), and every other code sets chan_en=00. At most one chan_en bit is ever high.
- R6: A read returns irq_req[1] in bit 5, irq_req[0] in bit 4, and the applied selection in bits 2..0. Bits 7, 6 and 3 read as 0. Written values of bits 7..3 have no effect.
- R7: Read data is shifted out MSB first. A master ACK after a byte makes the block send the byte again. A master NACK makes the block release SDA and stop driving until the next START.
- R8: A repeated START before the STOP discards a pending write. The following STOP leaves the selection unchanged.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. This holds with the system clock at 16 or more times the SCL rate.
- R10: ctrl_q always shows the same byte that a read would return: {00, irq_req, 0, selection}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x SCL |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr | input | 3 | Low three address bits |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| irq_req | input | 2 | Active-high interrupt request per channel |
| sda_pull | output | 1 | When 1, the data line is pulled low |
| chan_en | output | 2 | One-hot downstream channel enable |
| ctrl_q | output | 8 | Debug copy of the control byte |

## Verification
A pin edge reaches the cleaned lines about five clocks later. The reaction to an SCL fall shows on sda_pull about six clocks after the fall. A STOP reaches chan_en and ctrl_q about eight clocks after the SDA rise. The bench's master changes only one line at a time. After each change it waits a quarter bit of 16 clocks, which is twice the worst latency. All outputs are sampled on the falling clock edge, with inputs driven on that edge too. Selection changes are checked only after the STOP sequence has finished, and the checks that nothing moved yet are made after the data byte has been acknowledged and before the STOP.

// File: rtl/chansel_pkg.sv
package chansel_pkg;
  localparam int BYTE_W  = 8;
  localparam int SEL_W   = 3;
  localparam int STRAP_W = 3;
  localparam int IRQ_LSB = 4;
  localparam logic [3:0] ADDR_FIXED = 4'b1110;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_ACK,
    PH_WR,
    PH_WR_ACK,
    PH_RD,
    PH_RD_ACK
  } phase_t;
endpackage

// File: rtl/chansel_line_filter.sv
module chansel_line_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   VOTE_TAPS   = 3,
  parameter logic IDLE_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   tap_q;
  logic                   clean_q;

  function automatic logic vote(input logic [VOTE_TAPS-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < VOTE_TAPS; i++) n += int'(v[i]);
    return n > (VOTE_TAPS / 2);
  endfunction

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= IDLE_LEVEL;
        else     sync_q <= raw;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_q   <= {VOTE_TAPS{IDLE_LEVEL}};
      clean_q <= IDLE_LEVEL;
    end else begin
      tap_q   <= {tap_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      clean_q <= vote(tap_q);
    end
  end

  assign clean = clean_q;
endmodule

// File: rtl/chansel_bus_events.sv
module chansel_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl;
      sda_p <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_p;
  assign scl_fall  = ~scl & scl_p;
  assign start_evt = scl & scl_p & sda_p & ~sda;
  assign stop_evt  = scl & scl_p & ~sda_p & sda;

  // R9
  cond_excl_chk: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> !stop_evt);
endmodule

// File: rtl/chansel_target_fsm.sv
module chansel_target_fsm
  import chansel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_pull,
  output logic [SEL_W-1:0]  pend_sel,
  output logic              apply
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  phase_t              ph_q;
  logic [CNT_W-1:0]    bits_q;
  logic [BYTE_W-1:0]   shreg_q;
  logic                rw_q, mack_q, pull_q, pend_vld_q, apply_q;
  logic [SEL_W-1:0]    pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= PH_IDLE;
      bits_q     <= '0;
      shreg_q    <= '0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      pull_q     <= 1'b0;
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
      apply_q    <= 1'b0;
    end else begin
      apply_q <= 1'b0;
      if (start_evt) begin
        ph_q       <= PH_ADDR;
        bits_q     <= '0;
        pull_q     <= 1'b0;
        pend_vld_q <= 1'b0;
      end else if (stop_evt) begin
        ph_q       <= PH_IDLE;
        pull_q     <= 1'b0;
        pend_vld_q <= 1'b0;
        apply_q    <= pend_vld_q;
      end else begin
        case (ph_q)
          PH_IDLE: ;
          PH_ADDR: begin
            if (scl_rise && bits_q != FULL) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda};
              bits_q  <= bits_q + CNT_W'(1);
            end else if (scl_fall && bits_q == FULL) begin
              if (shreg_q[BYTE_W-1:1] == dev_addr) begin
                pull_q <= 1'b1;
                rw_q   <= shreg_q[0];
                ph_q   <= PH_ADDR_ACK;
              end else begin
                ph_q   <= PH_IDLE;
              end
            end
          end
          PH_ADDR_ACK: begin
            if (scl_fall) begin
              bits_q <= '0;
              if (rw_q) begin
                shreg_q <= rd_byte;
                pull_q  <= ~rd_byte[BYTE_W-1];
                ph_q    <= PH_RD;
              end else begin
                pull_q  <= 1'b0;
                ph_q    <= PH_WR;
              end
            end
          end
          PH_WR: begin
            if (scl_rise && bits_q != FULL) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda};
              bits_q  <= bits_q + CNT_W'(1);
            end else if (scl_fall && bits_q == FULL) begin
              pend_q     <= shreg_q[SEL_W-1:0];
              pend_vld_q <= 1'b1;
              pull_q     <= 1'b1;
              ph_q       <= PH_WR_ACK;
            end
          end
          PH_WR_ACK: begin
            if (scl_fall) begin
              pull_q <= 1'b0;
              bits_q <= '0;
              ph_q   <= PH_WR;
            end
          end
          PH_RD: begin
            if (scl_rise) begin
              bits_q <= bits_q + CNT_W'(1);
            end else if (scl_fall) begin
              if (bits_q == FULL) begin
                pull_q <= 1'b0;
                ph_q   <= PH_RD_ACK;
              end else begin
                pull_q  <= ~shreg_q[BYTE_W-2];
                shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
              end
            end
          end
          PH_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda;
            end else if (scl_fall) begin
              if (mack_q) begin
                bits_q  <= '0;
                shreg_q <= rd_byte;
                pull_q  <= ~rd_byte[BYTE_W-1];
                ph_q    <= PH_RD;
              end else begin
                pull_q  <= 1'b0;
                ph_q    <= PH_IDLE;
              end
            end
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign sda_pull = pull_q;
  assign pend_sel = pend_q;
  assign apply    = apply_q;

  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_IDLE) |-> !pull_q);
  // R8
  abort_pending_chk: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> !apply_q);
  // R2
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_WR_ACK && scl_fall) |=> !pull_q);
  // R2
  bit_count_chk: assert property (@(posedge clk) disable iff (rst)
    bits_q <= FULL);
endmodule

// File: rtl/chansel_i2c_top.sv
module chansel_i2c_top
  import chansel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3,
  parameter int CHANNELS    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [CHANNELS-1:0] irq_req,
  output logic               sda_pull,
  output logic [CHANNELS-1:0] chan_en,
  output logic [BYTE_W-1:0]  ctrl_q
);
  logic scl_c, sda_c;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic [SEL_W-1:0]    pend_sel, sel_q;
  logic                apply;
  logic [CHANNELS-1:0] irq_s1, irq_s2, chan_nx, chan_q;
  logic [BYTE_W-1:0]   rd_byte, ctrl_r;

  chansel_line_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS),
                        .IDLE_LEVEL(1'b1)) u_scl_flt (
    .clk(clk), .rst(rst), .raw(scl_in), .clean(scl_c));
  chansel_line_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS),
                        .IDLE_LEVEL(1'b1)) u_sda_flt (
    .clk(clk), .rst(rst), .raw(sda_in), .clean(sda_c));

  chansel_bus_events u_evt (
    .clk(clk), .rst(rst), .scl(scl_c), .sda(sda_c),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  chansel_target_fsm u_fsm (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .sda(sda_c), .dev_addr({ADDR_FIXED, strap_addr}),
    .rd_byte(rd_byte), .sda_pull(sda_pull),
    .pend_sel(pend_sel), .apply(apply));

  always_comb begin
    rd_byte = '0;
    rd_byte[IRQ_LSB +: CHANNELS] = irq_s2;
    rd_byte[SEL_W-1:0] = sel_q;
  end

  generate
    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_dec
      assign chan_nx[ch] = sel_q[SEL_W-1] && (sel_q[SEL_W-2:0] == (SEL_W-1)'(ch));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_s1 <= '0;
      irq_s2 <= '0;
      sel_q  <= '0;
      chan_q <= '0;
      ctrl_r <= '0;
    end else begin
      irq_s1 <= irq_req;
      irq_s2 <= irq_s1;
      if (apply) sel_q <= pend_sel;
      chan_q <= chan_nx;
      ctrl_r <= rd_byte;
    end
  end

  assign chan_en = chan_q;
  assign ctrl_q  = ctrl_r;

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !apply |=> $stable(sel_q));
  // R5
  chan_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chan_q));
  // R6
  ctrl_zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_r[7:6] == 2'b00) && (ctrl_r[3] == 1'b0));
endmodule

// File: tb/chansel_i2c_top_tb.sv
module chansel_i2c_top_tb_top;
  localparam int Q = 16;
  localparam int NVEC = 6;
  // entry: {write byte, irq_req, expected chan_en, expected read byte}
  localparam logic [19:0] VEC [0:NVEC-1] = '{
    {8'h04, 2'b00, 2'b01, 8'h04},
    {8'h05, 2'b01, 2'b10, 8'h15},
    {8'hFF, 2'b10, 2'b00, 8'h27},
    {8'h3D, 2'b11, 2'b10, 8'h35},
    {8'h06, 2'b00, 2'b00, 8'h06},
    {8'h03, 2'b00, 2'b00, 8'h03}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] strap = 3'b010;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] irq = 2'b00;
  logic sda_pull;
  logic [1:0] chan_en;
  logic [7:0] ctrl_q;
  wire  sda_line = sda_m & ~sda_pull;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  chansel_i2c_top dut_i (
    .clk(clk), .rst(rst), .strap_addr(strap), .scl_in(scl_m),
    .sda_in(sda_line), .irq_req(irq), .sda_pull(sda_pull),
    .chan_en(chan_en), .ctrl_q(ctrl_q));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_line; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~mack);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9: watchdog actual hung expected finished");
    finish_up();
  end

  initial begin
    logic a;
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R4 reset state
    chk("R4 chan_en", {6'd0, chan_en}, 8'h00);
    chk("R4 ctrl_q", ctrl_q, 8'h00);
    chk("R4 sda_pull", {7'd0, sda_pull}, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      irq = VEC[v][11:10];
      bus_start();
      put_byte(8'hE4, a); chk("R1 addr ack", {7'd0, a}, 8'h01);
      put_byte(VEC[v][19:12], a); chk("R2 data ack", {7'd0, a}, 8'h01);
      bus_stop();
      chk("R5 chan_en", {6'd0, chan_en}, {6'd0, VEC[v][9:8]});
      chk("R10 ctrl_q", ctrl_q, VEC[v][7:0]);
      bus_start();
      put_byte(8'hE5, a); chk("R1 read addr ack", {7'd0, a}, 8'h01);
      get_byte(rd, 1'b0);
      chk("R6 read byte", rd, VEC[v][7:0]);
      chk("R7 released after NACK", {7'd0, sda_pull}, 8'h00);
      bus_stop();
    end
    irq = 2'b00;

    // R3 pending until STOP (current selection 011)
    bus_start();
    put_byte(8'hE4, a);
    put_byte(8'h05, a);
    chk("R3 held before STOP chan_en", {6'd0, chan_en}, 8'h00);
    chk("R3 held before STOP ctrl_q", ctrl_q, 8'h03);
    bus_stop();
    chk("R9 STOP applies", {6'd0, chan_en}, 8'h02);

    // R3 last byte of a transfer wins
    bus_start();
    put_byte(8'hE4, a);
    put_byte(8'h05, a);
    put_byte(8'h04, a);
    bus_stop();
    chk("R3 last byte wins", {6'd0, chan_en}, 8'h01);

    // R8 repeated START discards pending write; R7 ACK then NACK read
    bus_start();
    put_byte(8'hE4, a);
    put_byte(8'h05, a);
    bus_start();
    put_byte(8'hE5, a);
    get_byte(rd, 1'b1);
    chk("R8 read sees old selection", rd, 8'h04);
    get_byte(rd, 1'b0);
    chk("R7 second byte after ACK", rd, 8'h04);
    chk("R7 released after NACK", {7'd0, sda_pull}, 8'h00);
    bus_stop();
    chk("R8 chan_en unchanged", {6'd0, chan_en}, 8'h01);

    // R1 other address ignored
    bus_start();
    put_byte(8'hE0, a); chk("R1 foreign addr no ack", {7'd0, a}, 8'h00);
    put_byte(8'h05, a); chk("R1 foreign data no ack", {7'd0, a}, 8'h00);
    bus_stop();
    chk("R1 foreign write ignored", {6'd0, chan_en}, 8'h01);

    // R1 strap change moves the address
    strap = 3'b000;
    repeat (4) @(negedge clk);
    bus_start();
    put_byte(8'hE0, a); chk("R1 new strap ack", {7'd0, a}, 8'h01);
    put_byte(8'h05, a);
    bus_stop();
    chk("R1 new strap write", {6'd0, chan_en}, 8'h02);

    // R6 upper written bits ignored, irq live
    irq = 2'b01;
    bus_start();
    put_byte(8'hE0, a);
    put_byte(8'hCC, a);
    bus_stop();
    chk("R6 masked write ctrl_q", ctrl_q, 8'h14);
    chk("R5 code 100", {6'd0, chan_en}, 8'h01);

    // R4 reset while a channel is active
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0; irq = 2'b00;
    repeat (6) @(negedge clk);
    chk("R4 reset chan_en", {6'd0, chan_en}, 8'h00);
    chk("R4 reset ctrl_q", ctrl_q, 8'h00);

    finish_up();
  end
endmodule